// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This block holds a parameterised set of independent 32-bit down-counting channels, reached through a single-cycle register port: address, write strobe, write data, and a read-data bus that answers in the same cycle. Each channel has a control register, an interval register and a current-count register. The three registers for channel n sit in a bank at offset 0x10 + 0x20·n.

A channel counts only when it is enabled. It counts on pulses from one of two tick-enable inputs, either the main oscillator tick or the alternate tick. A prescaler divides the chosen tick by a power of two. A channel either reloads and keeps running (periodic mode) or stops after its first expiry (single-shot mode).

Each expiry sets the channel's bit in a shared pending register. Software clears a pending bit by writing a 1 to it. A shared enable mask selects which pending bits drive the single level interrupt output. Software can read the complement of the current count as a free-running up counter.

Top module: `mtmr_top`

## Requirements
- R1: After reset every mapped register reads zero, no channel counts, no bit is pending and `irq` is low.
- R2: The interrupt mask is at 0x00 and the pending flags are at 0x04, with bit n belonging to channel n. The control register of channel n is at 0x10+0x20·n, its interval register at +0x4 and its current count at +0x8. Control reads back bits 7:0 as written, and its upper bits read zero.
- R3: Control bit 0 is the enable. Writing it from 0 to 1 copies the interval into the counter. Each divided tick then lowers the counter by one. Expiry is the divided tick on which the counter already holds 0.
- R4: When control bit 7 is 0 (periodic mode), expiry loads the interval into the counter again and the channel keeps running.
- R5: When control bit 7 is 1 (single-shot mode), expiry clears the enable bit and the counter stays at 0 on later ticks.
- R6: Control bits 3:2 choose the tick: code 1 takes `tick_osc`, code 2 takes `tick_pll`, and codes 0 and 3 take no tick. Pulses on the tick input that is not chosen leave the counter unchanged.
- R7: With control bits 6:4 = p, the counter steps once every 2^p pulses of the chosen tick. The first step comes on pulse 2^p after the enable.
- R8: Writing 1 to control bit 1 loads the interval into the counter on the next clock, and then the bit reads 0.
- R9: Every expiry sets the channel's pending bit, whatever the mask holds. `irq` is high when any pending bit has its mask bit set.
- R10: Writing the pending register clears exactly the bits written as 1 and leaves the bits written as 0.
- R11: Offsets that are not mapped read zero and ignore writes. A write to a current-count register leaves the count unchanged.
- R12: An interval of all ones gives a full 32-bit period. After k divided ticks the complement of the count reads k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the same cycle |
| tick_osc | input | 1 | Main oscillator tick enable |
| tick_pll | input | 1 | Alternate tick enable |
| irq | output | 1 | Level interrupt |

## Verification
The bench sweeps every channel through a full periodic cycle and reads the count after each tick. A design that expired one tick early or late would show a count that is off by one, or a pending bit at the wrong tick.

It runs a prescale sweep over several divide settings, with reads taken one pulse before and one pulse at the step boundary. This catches a prescale counter that is not cleared on enable, or a divide ratio of the wrong power.

It writes a pending register that holds two set flags, first with zeros and then with a single one. A design that cleared on any write, or cleared the whole register, fails here.

It starts a single-shot channel and keeps ticking after expiry. It also uses the reload bit and writes to unmapped offsets and to the read-only count. A design that kept running after a single-shot expiry, left the reload bit set, or decoded stray offsets would show it at the read port.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

  localparam int PSC_W = 7;

  // Control byte; field order matches the control bit layout (bit 7 .. bit 0).
  typedef struct packed {
    logic       one_shot;  // bit 7
    logic [2:0] psc;       // bits 6:4
    logic [1:0] src;       // bits 3:2
    logic       reload;    // bit 1
    logic       en;        // bit 0
  } ctrl_t;

  localparam logic [1:0] SRC_OSC = 2'd1;
  localparam logic [1:0] SRC_PLL = 2'd2;

  // Pick the tick for a source code; codes 0 and 3 never tick.
  function automatic logic src_tick(input logic [1:0] src, input logic t_osc,
                                    input logic t_pll);
    case (src)
      SRC_OSC: return t_osc;
      SRC_PLL: return t_pll;
      default: return 1'b0;
    endcase
  endfunction

  // True on every 2^p-th pulse: the low p bits of the pulse count are all ones.
  function automatic logic psc_hit(input logic [PSC_W-1:0] pcnt, input logic [2:0] p);
    logic [PSC_W-1:0] mask;
    mask = (PSC_W'(1) << p) - PSC_W'(1);
    return (pcnt & mask) == mask;
  endfunction

endpackage

// File: rtl/mtmr_chan.sv
module mtmr_chan
  import mtmr_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_intv,
  input  logic [CW-1:0] wdata,
  input  logic          tick_osc,
  input  logic          tick_pll,
  output ctrl_t         ctrl_q,
  output logic [CW-1:0] intv_q,
  output logic [CW-1:0] cnt_q,
  output logic          step,
  output logic          expire
);

  logic [PSC_W-1:0] pcnt_q;
  logic             sel_tick;
  logic             cnt_zero;

  assign sel_tick = ctrl_q.en && src_tick(ctrl_q.src, tick_osc, tick_pll);
  assign step     = sel_tick && psc_hit(pcnt_q, ctrl_q.psc);
  assign cnt_zero = (cnt_q == '0);
  assign expire   = step && cnt_zero && !ctrl_q.reload && !wr_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      intv_q <= '0;
      cnt_q  <= '0;
      pcnt_q <= '0;
    end else begin
      if (wr_intv) intv_q <= wdata;
      if (wr_ctrl) begin
        ctrl_q <= ctrl_t'(wdata[7:0]);
        if (wdata[0] && !ctrl_q.en) begin
          cnt_q  <= intv_q;
          pcnt_q <= '0;
        end
      end else begin
        if (sel_tick) pcnt_q <= pcnt_q + PSC_W'(1);
        if (ctrl_q.reload) begin
          cnt_q         <= intv_q;
          ctrl_q.reload <= 1'b0;
        end else if (step) begin
          if (cnt_zero) begin
            if (ctrl_q.one_shot) ctrl_q.en <= 1'b0;
            else                 cnt_q     <= intv_q;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
      end
    end
  end

endmodule

// File: rtl/mtmr_irq.sv
module mtmr_irq #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_mask,
  input  logic           wr_stat,
  input  logic [NCH-1:0] wbits,
  input  logic [NCH-1:0] expire,
  output logic [NCH-1:0] mask_q,
  output logic [NCH-1:0] pend_q,
  output logic           irq
);

  logic [NCH-1:0] clr;

  assign clr = wr_stat ? wbits : '0;
  assign irq = |(pend_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      if (wr_mask) mask_q <= wbits;
      pend_q <= (pend_q & ~clr) | expire;  // a new expiry wins over a same-cycle clear
    end
  end

endmodule

// File: rtl/mtmr_top.sv
module mtmr_top
  import mtmr_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tick_osc,
  input  logic              tick_pll,
  output logic              irq
);

  localparam int CW      = 32;
  localparam int BANK0   = 16;
  localparam int STR_LG  = 5;
  localparam int IDX_W   = ADDR_W - STR_LG;
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4);

  logic [ADDR_W-1:0]         off;
  logic                      in_bank;
  logic [IDX_W-1:0]          idx;
  logic [STR_LG-1:0]         sub;
  logic                      wr_mask, wr_stat;
  logic [NCH-1:0]            wr_ctrl, wr_intv, hit;
  logic [NCH-1:0][7:0]       ctrl_a;
  logic [NCH-1:0][CW-1:0]    intv_a, cnt_a;
  logic [NCH-1:0]            step_a, expire;
  logic [NCH-1:0]            mask_q, pend_q;

  assign off     = bus_addr - ADDR_W'(BANK0);
  assign in_bank = (bus_addr >= ADDR_W'(BANK0));
  assign idx     = off[ADDR_W-1:STR_LG];
  assign sub     = off[STR_LG-1:0];
  assign wr_mask = bus_we && (bus_addr == A_MASK);
  assign wr_stat = bus_we && (bus_addr == A_STAT);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ctrl_t ctrl_s;
    assign hit[i]     = in_bank && (idx == IDX_W'(i));
    assign wr_ctrl[i] = bus_we && hit[i] && (sub == STR_LG'(0));
    assign wr_intv[i] = bus_we && hit[i] && (sub == STR_LG'(4));
    assign ctrl_a[i]  = ctrl_s;

    mtmr_chan #(.CW(CW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctrl  (wr_ctrl[i]),
      .wr_intv  (wr_intv[i]),
      .wdata    (bus_wdata),
      .tick_osc (tick_osc),
      .tick_pll (tick_pll),
      .ctrl_q   (ctrl_s),
      .intv_q   (intv_a[i]),
      .cnt_q    (cnt_a[i]),
      .step     (step_a[i]),
      .expire   (expire[i])
    );
  end

  mtmr_irq #(.NCH(NCH)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_mask (wr_mask),
    .wr_stat (wr_stat),
    .wbits   (bus_wdata[NCH-1:0]),
    .expire  (expire),
    .mask_q  (mask_q),
    .pend_q  (pend_q),
    .irq     (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_MASK) bus_rdata = CW'(mask_q);
    if (bus_addr == A_STAT) bus_rdata = CW'(pend_q);
    for (int i = 0; i < NCH; i++) begin
      if (hit[i]) begin
        case (sub)
          STR_LG'(0): bus_rdata = CW'(ctrl_a[i]);
          STR_LG'(4): bus_rdata = intv_a[i];
          STR_LG'(8): bus_rdata = cnt_a[i];
          default:    bus_rdata = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/mtmr_chk.sv
module mtmr_chk #(
  parameter int NCH = 4,
  parameter int CW  = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCH-1:0][7:0]    ctrl_a,
  input logic [NCH-1:0][CW-1:0] intv_a,
  input logic [NCH-1:0][CW-1:0] cnt_a,
  input logic [NCH-1:0]         step_a,
  input logic [NCH-1:0]         expire,
  input logic [NCH-1:0]         wr_ctrl,
  input logic [NCH-1:0]         pend_q,
  input logic                   wr_stat,
  input logic [NCH-1:0]         wbits
);

  for (genvar i = 0; i < NCH; i++) begin : g_a
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      step_a[i] && cnt_a[i] != '0 && !ctrl_a[i][1] && !wr_ctrl[i] |=> cnt_a[i] == $past(cnt_a[i]) - CW'(1)); // R3
    AST_PERIOD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      expire[i] && !ctrl_a[i][7] |=> cnt_a[i] == $past(intv_a[i])); // R4
    AST_SHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      expire[i] && ctrl_a[i][7] |=> !ctrl_a[i][0]); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !step_a[i] && !ctrl_a[i][1] && !wr_ctrl[i] |=> $stable(cnt_a[i])); // R6
    AST_RELOAD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_a[i][1] && !wr_ctrl[i] |=> !ctrl_a[i][1] && cnt_a[i] == $past(intv_a[i])); // R8
    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
      expire[i] |=> pend_q[i]); // R9
    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_q[i]) |-> $past(wr_stat && wbits[i])); // R10
  end

endmodule

bind mtmr_top mtmr_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ctrl_a  (ctrl_a),
  .intv_a  (intv_a),
  .cnt_a   (cnt_a),
  .step_a  (step_a),
  .expire  (expire),
  .wr_ctrl (wr_ctrl),
  .pend_q  (pend_q),
  .wr_stat (wr_stat),
  .wbits   (bus_wdata[NCH-1:0])
);

// File: tb/mtmr_top_tb.sv
`timescale 1ns/1ps
module mtmr_top_tb;

  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_osc = 1'b0;
  logic        tick_pll = 1'b0;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  mtmr_top #(.NCH(NCH), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_osc(tick_osc),
    .tick_pll(tick_pll), .irq(irq)
  );

  function automatic logic [7:0] bank(input int ch, input int sub);
    return 8'(16 + 32 * ch + sub);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    #1;
    d = bus_rdata;
  endtask

  task automatic tk(input logic o, input logic p, input int n);
    for (int k = 0; k < n; k++) begin
      tick_osc = o; tick_pll = p;
      @(posedge clk); #1;
      tick_osc = 1'b0; tick_pll = 1'b0;
    end
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state of every offset in the map
    for (int a = 0; a < 16 + 32 * NCH; a += 4) begin
      rd(8'(a), v);
      chk("R1 reset read", v, 32'h0);
    end
    chk("R1 irq low", {31'h0, irq}, 32'h0);

    // R2: decode and control readback, upper bits read zero
    for (int ch = 0; ch < NCH; ch++) begin
      wr(bank(ch, 4), 32'h100 + ch);
      wr(bank(ch, 0), 32'hFFFF_FF08 | (ch << 4));
      rd(bank(ch, 4), v); chk("R2 interval", v, 32'h100 + ch);
      rd(bank(ch, 0), v); chk("R2 ctrl", v, 32'h08 | (ch << 4));
      wr(bank(ch, 0), 32'h0);
    end
    wr(8'h00, 32'h5); rd(8'h00, v); chk("R2 mask", v, 32'h5);
    wr(8'h00, 32'h0);

    // R3/R4/R9: full periodic cycle on each channel, osc source, no divide
    for (int ch = 0; ch < NCH; ch++) begin
      int n = 3 + ch;
      wr(bank(ch, 4), n);
      wr(bank(ch, 0), 32'h05);
      rd(bank(ch, 8), v); chk("R3 load on enable", v, n);
      for (int k = 1; k <= n; k++) begin
        tk(1'b1, 1'b0, 1);
        rd(bank(ch, 8), v); chk("R3 count down", v, n - k);
      end
      rd(8'h04, v); chk("R3 no early expiry", v, 32'h0);
      tk(1'b1, 1'b0, 1);
      rd(8'h04, v); chk("R9 pending on expiry", v, 32'h1 << ch);
      rd(bank(ch, 8), v); chk("R4 periodic reload", v, n);
      chk("R9 masked irq low", {31'h0, irq}, 32'h0);
      wr(8'h00, 32'h1 << ch);
      chk("R9 irq high", {31'h0, irq}, 32'h1);
      wr(8'h00, 32'h0);
      wr(bank(ch, 0), 32'h0);
      wr(8'h04, 32'hF);
      rd(8'h04, v); chk("R10 clear", v, 32'h0);
    end

    // R5: single shot
    wr(bank(0, 4), 32'd2);
    wr(bank(0, 0), 32'h85);
    tk(1'b1, 1'b0, 3);
    rd(8'h04, v); chk("R5 pending", v, 32'h1);
    rd(bank(0, 0), v); chk("R5 enable cleared", v, 32'h84);
    tk(1'b1, 1'b0, 2);
    rd(bank(0, 8), v); chk("R5 stays zero", v, 32'h0);
    wr(bank(0, 0), 32'h0); wr(8'h04, 32'hF);

    // R6: source selection
    wr(bank(1, 4), 32'd10);
    wr(bank(1, 0), 32'h09);
    tk(1'b1, 1'b0, 3);
    rd(bank(1, 8), v); chk("R6 osc ignored for code 2", v, 32'd10);
    tk(1'b0, 1'b1, 3);
    rd(bank(1, 8), v); chk("R6 pll counts", v, 32'd7);
    wr(bank(1, 0), 32'h0);
    wr(bank(1, 0), 32'h01);
    tk(1'b1, 1'b1, 4);
    rd(bank(1, 8), v); chk("R6 code 0 no tick", v, 32'd10);
    wr(bank(1, 0), 32'h0);
    wr(bank(1, 0), 32'h0D);
    tk(1'b1, 1'b1, 4);
    rd(bank(1, 8), v); chk("R6 code 3 no tick", v, 32'd10);
    wr(bank(1, 0), 32'h0);

    // R7: prescale sweep
    wr(bank(2, 4), 32'd100);
    for (int p = 0; p < 4; p++) begin
      wr(bank(2, 0), 32'h0);
      wr(bank(2, 0), (p << 4) | 32'h05);
      tk(1'b1, 1'b0, 3 * (1 << p) - 1);
      rd(bank(2, 8), v); chk("R7 before step", v, 32'd98);
      tk(1'b1, 1'b0, 1);
      rd(bank(2, 8), v); chk("R7 at step", v, 32'd97);
    end
    wr(bank(2, 0), 32'h0);

    // R8: reload request
    wr(bank(3, 4), 32'd20);
    wr(bank(3, 0), 32'h05);
    tk(1'b1, 1'b0, 5);
    wr(bank(3, 4), 32'd50);
    rd(bank(3, 8), v); chk("R8 interval write no load", v, 32'd15);
    wr(bank(3, 0), 32'h07);
    @(posedge clk); #1;
    rd(bank(3, 8), v); chk("R8 reload", v, 32'd50);
    rd(bank(3, 0), v); chk("R8 bit self clears", v, 32'h05);
    wr(bank(3, 0), 32'h0);

    // R10: write-one-to-clear with two bits pending
    wr(8'h04, 32'hF);
    wr(bank(0, 4), 32'd0); wr(bank(1, 4), 32'd0);
    wr(bank(0, 0), 32'h05); wr(bank(1, 0), 32'h05);
    tk(1'b1, 1'b0, 1);
    wr(bank(0, 0), 32'h0); wr(bank(1, 0), 32'h0);
    rd(8'h04, v); chk("R10 both pending", v, 32'h3);
    wr(8'h04, 32'h0);
    rd(8'h04, v); chk("R10 zero write keeps", v, 32'h3);
    wr(8'h04, 32'h1);
    rd(8'h04, v); chk("R10 one bit cleared", v, 32'h2);
    wr(8'h04, 32'h2);

    // R11: unmapped offsets and read-only count
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, v); chk("R11 unmapped 08", v, 32'h0);
    wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, v); chk("R11 unmapped 1C", v, 32'h0);
    wr(8'h90, 32'hFFFF_FFFF); rd(8'h90, v); chk("R11 beyond banks", v, 32'h0);
    rd(bank(3, 8), v);
    wr(bank(3, 8), 32'h1234);
    begin
      logic [31:0] w;
      rd(bank(3, 8), w); chk("R11 count read only", w, v);
    end
    rd(8'h00, v); chk("R11 mask untouched", v, 32'h0);

    // R12: all-ones interval, complement reads elapsed ticks
    wr(bank(0, 4), 32'hFFFF_FFFF);
    wr(bank(0, 0), 32'h05);
    tk(1'b1, 1'b0, 5);
    rd(bank(0, 8), v); chk("R12 up count", ~v, 32'd5);
    wr(bank(0, 0), 32'h0);

    finish_run();
  end

endmodule